// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Port

This block is a word-oriented synchronous serial port. It can be a master or a slave. Software configures it through a small register file. As a master it runs one of three frame formats:

- a clocked-select format with programmable clock polarity and phase,
- a framed format that announces each word with a one-period high pulse on frame select,
- a half-duplex format that sends an 8-bit command and then reads back a data word.

As a slave it takes part in the clocked-select format, driven by an external master. The word length can be set from 4 to 16 bits.

The serial clock comes from two dividers in series. The first is an even prescaler and the second divides by one plus an 8-bit rate value. A full serial clock period therefore lasts prescale × (1 + rate) system clocks. Each register bank holds one word at a time: there is one transmit word and one received word. A busy flag tracks the frame in progress.

Register addresses:

| Address | Name | Access |
|---|---|---|
| 0 | format control | read/write |
| 1 | mode control | read/write |
| 2 | prescale | read/write |
| 3 | data | write loads the transmit word, read returns the received word |
| 4 | status | read only |

Top module: `sync_serial_port`

## Requirements
- R1: The serial clock period is P × (1 + rate) system clocks. P is the prescale register with bit 0 forced to zero, and any value below 2 acts as 2. Each half period lasts (P/2) × (1 + rate) clocks.
- R2: Format control bit fields:
  - bits 15:8 hold the rate.
  - bit 7 holds the phase.
  - bit 6 holds the polarity.
  - bits 5:4 select the format: 00 clocked-select, 01 framed, 10 command/response.
  - bits 3:0 hold the word length minus one. Values below 3 select 4 bits, and 0x1817 gives 8-bit framed words with rate 0x18.
- R3: Mode control bit fields are bit 1 enable, bit 2 slave and bit 3 slave-output-off. While enabled, writes to format control, prescale and mode control bits 3:2 are ignored. The enable bit can always be written, and clearing it ends a frame in progress within two clocks.
- R4: A data write while the port is enabled and idle starts a frame. Status bit 0 (busy) is then high from the next clock until the frame ends. A data write while the port is busy or disabled is ignored.
- R5: Clocked-select master timing:
  - frame select is low for 2L half periods, where L is the word length.
  - the serial clock equals polarity XOR phase in even half periods and the inverse in odd ones.
  - data is sent MSB first, one bit per pair of half periods.
  - when idle, the clock sits at the polarity level and frame select is high.
- R6: Framed master timing:
  - frame select is high for the first two half periods, then the L data bits follow.
  - the clock is high in even half periods and low in odd ones.
  - when idle, the clock and frame select are both low, and the data line is low during the pulse.
- R7: Command/response master timing:
  - frame select is low for 16 + 2L half periods.
  - the clock is low in even half periods and high in odd ones.
  - data bits 7:0 are sent MSB first in the first 16 half periods, then the data line is held low.
- R8: The master samples the input line at the end of each even half period that carries data bit positions. Sampling starts at half period 0 for clocked-select, 2 for framed and 16 for command/response. The received word appears right-justified with zero upper bits at the data address once busy falls.
- R9: A slave in clocked-select format works as follows:
  - it puts the transmit word on its data output MSB first.
  - it moves to the next bit after each capture edge. The capture edge is the edge leaving the idle level when phase is 0, and the edge returning to it when phase is 1.
  - after L captures it stores the received word and clears busy.
  - frame select high resets the bit count.
- R10: A slave with the output-off bit set holds its data output enable low but still receives words.
- R11: After reset all registers read zero, busy is low, the serial clock is low, frame select is high, the data output is low and the output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| sck_out | output | 1 | Serial clock driven as master |
| fs_out | output | 1 | Frame select driven as master |
| sd_out | output | 1 | Serial data output |
| sd_oe | output | 1 | Output enable for sd_out; low means high impedance |
| sck_in | input | 1 | Serial clock received as slave |
| fs_in | input | 1 | Frame select received as slave (active low) |
| sd_in | input | 1 | Serial data input |

## Verification
The bench targets these corner cases:
- **Divider off-by-one.** Each master frame is checked clock by clock, so a divider that is one count out shifts every later edge and shows up early in the frame.
- **Word-length floor and prescale clamp.** Words shorter than the floor and a prescale of zero or an odd value are exercised. Without the clamp the clock would stall or run at the wrong rate.
- **Late sampling.** The input pattern changes every clock, so a design that samples one half period late collects a different received word.
- **Frozen configuration.** A configuration write while enabled and a data write mid-frame are both issued. If either were accepted, the readback would change or the frame would restart.
- **Slave edge selection.** Both slave phases are run. A slave that captures on the wrong edge returns a shifted word and presents its bits one position off.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        sck_out,
  output logic        fs_out,
  output logic        sd_out,
  output logic        sd_oe,
  input  logic        sck_in,
  input  logic        fs_in,
  input  logic        sd_in
);
  logic [15:0] c0, txw, rxw, rsr;
  logic [2:0]  c1;
  logic [7:0]  pre, rc;
  logic [6:0]  pc;
  logic [5:0]  j;
  logic [3:0]  sn;
  logic        busy;
  logic [SYNC:0]   sck_q;
  logic [SYNC-1:0] fs_q, sd_q;

  wire       en    = c1[0];
  wire       slv   = c1[1];
  wire       odis  = c1[2];
  wire [7:0] rate  = c0[15:8];
  wire       ph    = c0[7];
  wire       pol   = c0[6];
  wire       is_ti = c0[5:4] == 2'b01;
  wire       is_mw = c0[5:4] == 2'b10;
  wire       is_spi = !is_ti && !is_mw;
  wire [3:0] lm1   = (c0[3:0] < 4'd3) ? 4'd3 : c0[3:0];
  wire [6:0] hp    = (pre[7:1] == 7'd0) ? 7'd1 : pre[7:1];

  wire [5:0] base  = is_ti ? 6'd2 : (is_mw ? 6'd16 : 6'd0);
  wire [5:0] nh    = base + {1'b0, lm1, 1'b0} + 6'd2;
  wire       act   = busy && en && !slv;
  wire       hend  = (pc == hp - 7'd1) && (rc == rate);
  wire       in_dat = j >= base;
  wire [4:0] dj    = j[4:0] - base[4:0];
  wire [3:0] bidx  = lm1 - dj[4:1];
  wire [3:0] cidx  = 4'd7 - {1'b0, j[3:1]};
  wire       mbit  = in_dat ? (!is_mw && txw[bidx]) : (is_mw && txw[cidx]);
  wire       samp  = act && hend && in_dat && !dj[0];

  wire sck_s = sck_q[SYNC-1];
  wire sck_p = sck_q[SYNC];
  wire fs_s  = fs_q[SYNC-1];
  wire sd_s  = sd_q[SYNC-1];
  wire sedge = sck_s != sck_p;
  wire cap   = sedge && ((sck_s == pol) == ph);

  assign sck_out = is_spi ? (act ? (pol ^ j[0] ^ ph) : pol)
                 : is_ti  ? (act && !j[0]) : (act && j[0]);
  assign fs_out  = is_ti ? (act && j < 6'd2) : !act;
  assign sd_out  = slv ? txw[lm1 - sn] : (act && mbit);
  assign sd_oe   = !(slv && odis);

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = c0;
      3'd1: rd_data = {12'd0, c1, 1'b0};
      3'd2: rd_data = {8'd0, pre};
      3'd3: rd_data = rxw;
      3'd4: rd_data = {15'd0, busy};
      default: rd_data = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; pre <= '0; txw <= '0; rxw <= '0; rsr <= '0;
      busy <= 1'b0; j <= '0; pc <= '0; rc <= '0; sn <= '0;
      sck_q <= '0; fs_q <= '1; sd_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC-1:0], sck_in};
      fs_q  <= {fs_q[SYNC-2:0], fs_in};
      sd_q  <= {sd_q[SYNC-2:0], sd_in};
      if (act) begin
        if (pc == hp - 7'd1) begin
          pc <= '0;
          rc <= (rc == rate) ? 8'd0 : rc + 8'd1;
        end else pc <= pc + 7'd1;
        if (hend) begin
          j <= j + 6'd1;
          if (samp) rsr <= {rsr[14:0], sd_in};
          if (j == nh - 6'd1) begin
            busy <= 1'b0;
            rxw  <= rsr;
          end
        end
      end
      if (slv && en) begin
        if (fs_s) begin
          sn <= '0; rsr <= '0;
        end else if (cap) begin
          rsr <= {rsr[14:0], sd_s};
          if (sn == lm1) begin
            sn <= '0; busy <= 1'b0; rxw <= {rsr[14:0], sd_s};
          end else sn <= sn + 4'd1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (!en) c0 <= wr_data;
          3'd1: c1 <= en ? {c1[2:1], wr_data[1]} : wr_data[3:1];
          3'd2: if (!en) pre <= {wr_data[7:1], 1'b0};
          3'd3: if (en && !busy) begin
            txw <= wr_data; busy <= 1'b1;
            j <= '0; pc <= '0; rc <= '0;
            if (!slv) rsr <= '0;
          end
          default: ;
        endcase
      end
      if (!en) busy <= 1'b0;
    end
  end

  assert_start_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_addr == 3'd3 && en));
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(c0) && $stable(pre)));
  assert_half_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (j < nh && pc < hp && rc <= rate));
  assert_end_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(act)) |-> $past(hend));
  assert_select_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && is_spi) |-> !fs_out);
endmodule

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0, rd_addr = 3'd4;
  logic [15:0] wr_data = 16'd0, rd_data;
  logic sck_out, fs_out, sd_out, sd_oe;
  logic sck_in = 1'b0, fs_in = 1'b1, sd_in = 1'b0;
  int nchk = 0, nfail = 0;
  logic [15:0] lf = 16'hACE1;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sck_out(sck_out), .fs_out(fs_out),
    .sd_out(sd_out), .sd_oe(sd_oe), .sck_in(sck_in), .fs_in(fs_in), .sd_in(sd_in));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    rd_addr = a; #1; chk(req, int'(rd_data), exp); rd_addr = 3'd4;
  endtask

  task automatic master(input int fmt, input int pol, input int ph, input int dss,
                        input int pre, input int rate, input int tx);
    int p, h, l, n_h, base, erx, j, esck, efs, esd, eb;
    string rq;
    p = pre & 254; if (p < 2) p = 2;
    h = (p / 2) * (rate + 1);
    l = ((dss < 3) ? 3 : dss) + 1;
    base = (fmt == 1) ? 2 : (fmt == 2) ? 16 : 0;
    n_h = base + 2 * l;
    rq = (fmt == 0) ? "R5" : (fmt == 1) ? "R6" : "R7";
    erx = 0;
    wr(1, 0);
    wr(0, (rate << 8) | (ph << 7) | (pol << 6) | (fmt << 4) | dss);
    wr(2, pre); wr(1, 2); wr(3, tx);
    for (int n = 0; n <= n_h * h + 2; n++) begin
      j = n / h;
      if (j >= n_h) begin
        esck = (fmt == 0) ? pol : 0; efs = (fmt == 1) ? 0 : 1; esd = 0; eb = 0;
      end else begin
        eb = 1;
        if (fmt == 0) begin
          esck = pol ^ (j % 2) ^ ph; efs = 0; esd = (tx >> (l - 1 - j / 2)) & 1;
        end else if (fmt == 1) begin
          esck = (j % 2 == 0) ? 1 : 0; efs = (j < 2) ? 1 : 0;
          esd = (j < 2) ? 0 : (tx >> (l - 1 - (j - 2) / 2)) & 1;
        end else begin
          esck = j % 2; efs = 0; esd = (j < 16) ? (tx >> (7 - j / 2)) & 1 : 0;
        end
      end
      chk({rq, " sck (R1 timing)"}, int'(sck_out), esck);
      chk({rq, " fs"}, int'(fs_out), efs);
      chk({rq, " sd"}, int'(sd_out), esd);
      chk("R4 busy", int'(rd_data[0]), eb);
      if (n == 3) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hFFFF; end
      if (n == 4) wr_en = 1'b0;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sd_in = lf[0];
      if ((n + 1) % h == 0 && j < n_h && j >= base && (j - base) % 2 == 0)
        erx = (erx << 1) | int'(sd_in);
      @(negedge clk);
    end
    rd_chk(3, erx, "R8 rx word");
  endtask

  task automatic slave(input int pol, input int ph, input int dss, input int tx,
                       input int rxp, input int od);
    int l;
    l = dss + 1;
    wr(1, 0);
    sck_in = pol[0]; fs_in = 1'b1;
    wr(0, (ph << 7) | (pol << 6) | dss);
    wr(1, (od != 0) ? 14 : 6);
    wr(3, tx);
    repeat (4) @(negedge clk);
    fs_in = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < l; b++) begin
      sd_in = rxp[l - 1 - b];
      if (ph == 0) begin
        chk("R9 slave sd", int'(sd_out), (tx >> (l - 1 - b)) & 1);
        chk("R10 oe", int'(sd_oe), (od != 0) ? 0 : 1);
        sck_in = !pol[0]; repeat (8) @(negedge clk);
        sck_in = pol[0];  repeat (8) @(negedge clk);
      end else begin
        sck_in = !pol[0]; repeat (8) @(negedge clk);
        chk("R9 slave sd", int'(sd_out), (tx >> (l - 1 - b)) & 1);
        chk("R10 oe", int'(sd_oe), (od != 0) ? 0 : 1);
        sck_in = pol[0];  repeat (8) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    chk("R9 busy clear", int'(rd_data[0]), 0);
    rd_chk(3, rxp & ((1 << l) - 1), (od != 0) ? "R10 rx" : "R9 rx");
    fs_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(0, 0, "R11 ctl0");
    rd_chk(4, 0, "R11 busy");
    chk("R11 sck", int'(sck_out), 0);
    chk("R11 fs", int'(fs_out), 1);
    chk("R11 sd", int'(sd_out), 0);
    chk("R11 oe", int'(sd_oe), 1);
    wr(0, 16'h1817);
    rd_chk(0, 16'h1817, "R2 ctl0 readback");

    master(0, 0, 0, 7, 2, 1, 16'h00A5);
    master(0, 1, 1, 11, 4, 2, 16'h09C3);
    master(0, 0, 1, 1, 3, 0, 16'h000B);
    master(0, 1, 0, 15, 0, 0, 16'hF00F);
    master(1, 0, 0, 7, 2, 24, 16'h005A);
    master(2, 0, 0, 7, 2, 0, 16'h00D2);
    master(2, 0, 0, 11, 6, 0, 16'h003E);

    wr(0, 16'hFFFF);
    rd_chk(0, 16'h002B, "R3 ctl0 frozen");
    wr(2, 16'h0040);
    rd_chk(2, 6, "R3 prescale frozen");
    wr(1, 14);
    rd_chk(1, 2, "R3 mode frozen");

    wr(1, 0); wr(0, 16'h0007); wr(2, 2); wr(1, 2); wr(3, 16'h0055);
    repeat (5) @(negedge clk);
    wr(1, 0);
    repeat (2) @(negedge clk);
    chk("R3 abort busy", int'(rd_data[0]), 0);
    chk("R3 abort sck", int'(sck_out), 0);
    chk("R3 abort fs", int'(fs_out), 1);

    wr(3, 16'h1234);
    chk("R4 disabled write", int'(rd_data[0]), 0);
    chk("R4 disabled fs", int'(fs_out), 1);

    slave(0, 0, 7, 16'h00B4, 16'h0069, 0);
    slave(1, 1, 15, 16'hC3A5, 16'h5E71, 0);
    slave(0, 1, 11, 16'h0A5C, 16'h0937, 1);

    summary();
    $finish;
  end
endmodule